// File: doc/BRIEF.md
# Canonical Linear Address Checker

This block sits in the address path of a 64-bit-mode load/store unit. For each memory access it takes the effective offset, the segment the access goes through, the two segment bases that still count in 64-bit mode and the access size. From these it forms the linear address and decides whether the access must fault because some byte it touches lies outside canonical space. Every byte of a multi-byte access is covered by checking both the first and the last byte. The last byte address wraps modulo 2^64. When a fault is raised, it is classed as a stack fault or a general-protection fault.

The implemented virtual address width is a parameter (48 by default, 48 to 57 allowed). Results appear one clock after the access is presented. Paging, translation lookup and legacy-mode segment limits are not part of this block.

Top module: `lac_top`

## Requirements
- R1: The segment code on `seg_sel` is ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. For FS the linear address is `offset + fs_base`, and for GS it is `offset + gs_base`, both modulo 2^64.
- R2: For ES, CS, SS, DS and the unused codes 6 and 7, the linear address equals the offset, and both base inputs have no effect on it.
- R3: An address is canonical when bits 63 down to VA_WIDTH-1 are all equal. With the default width of 48, the ranges 0x0000_0000_0000_0000..0x0000_7FFF_FFFF_FFFF and 0xFFFF_8000_0000_0000..0xFFFF_FFFF_FFFF_FFFF pass. A first byte outside these ranges raises a fault.
- R4: The last byte address is linear + size - 1. A fault is raised when the last byte is non-canonical, even if the first byte is canonical.
- R5: The last byte address wraps modulo 2^64. An access starting at 0xFFFF_FFFF_FFFF_FFFF with size 2 touches address 0 and does not fault.
- R6: A fault on an access through SS (code 2), or on one with `stack_base`=1 (RSP/RBP base), has `fault_stack`=1. Any other fault has `fault_stack`=0. `fault_stack` is 0 whenever `fault` is 0.
- R7: No segment limit applies. Any fully canonical access does not fault, whatever its offset.
- R8: `acc_size` is the byte count 1 to 16. A size of 0 is treated as 1, and a size above 16 is treated as 16.
- R9: `out_valid` follows `in_valid` with a one-cycle latency, and `fault` is only 1 while `out_valid` is 1. Reset clears `out_valid`, `lin_addr`, `fault` and `fault_stack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access presented this cycle |
| offset | input | 64 | Effective offset |
| seg_sel | input | 3 | Segment code (R1) |
| fs_base | input | 64 | FS base |
| gs_base | input | 64 | GS base |
| acc_size | input | 5 | Access size in bytes |
| stack_base | input | 1 | RSP or RBP used as base register |
| out_valid | output | 1 | Result valid |
| lin_addr | output | 64 | Linear address of the first byte |
| fault | output | 1 | Non-canonical access |
| fault_stack | output | 1 | Fault class: 1 stack fault, 0 general protection |

## Verification
Two functions meet in a single cycle when a stack-class access straddles the canonical boundary. In that case the span check and the fault steering both have to act on the same access. The bench provokes this with an RSP-based DS access whose first byte is the last canonical low address and whose size carries the last byte across the boundary. It expects a fault with the stack class.

A second overlap is the FS base addition meeting the span check. Here a base pushes an otherwise canonical offset out of range, or a wrap at the top of the space brings the last byte back to zero. Both cases are judged against addresses worked out by hand.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned SIZE_W = 5;
  localparam int unsigned MAX_BYTES = 16;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_e;

  // true when bits 63..w-1 are all zero or all one
  function automatic logic addr_is_canon(input logic [ADDR_W-1:0] a, input int unsigned w);
    logic [ADDR_W-1:0] upper;
    logic [ADDR_W-1:0] ones;
    upper = a >> (w - 1);
    ones  = {ADDR_W{1'b1}} >> (w - 1);
    return (upper == '0) || (upper == ones);
  endfunction

  // distance from first to last byte, after clamping the size to 1..MAX_BYTES
  function automatic logic [ADDR_W-1:0] span_of(input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] eff;
    if (sz == '0) eff = SIZE_W'(1);
    else if (sz > SIZE_W'(MAX_BYTES)) eff = SIZE_W'(MAX_BYTES);
    else eff = sz;
    return ADDR_W'(eff - SIZE_W'(1));
  endfunction
endpackage

// File: rtl/lac_base_sel.sv
module lac_base_sel
  import lac_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [2:0]    seg_sel,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] fs_base,
  input  logic [AW-1:0] gs_base,
  output logic [AW-1:0] lin
);
  logic [AW-1:0] base;

  always_comb begin
    unique case (seg_sel)
      SEG_FS:  base = fs_base;
      SEG_GS:  base = gs_base;
      default: base = '0;
    endcase
    lin = offset + base;
  end
endmodule

// File: rtl/lac_span_check.sv
module lac_span_check
  import lac_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned VA_WIDTH = 48
) (
  input  logic [AW-1:0]     first_addr,
  input  logic [SIZE_W-1:0] acc_size,
  output logic [AW-1:0]     last_addr,
  output logic              first_bad,
  output logic              last_bad
);
  assign last_addr = first_addr + span_of(acc_size);

  generate
    if (VA_WIDTH >= AW) begin : g_full
      assign first_bad = 1'b0;
      assign last_bad  = 1'b0;
    end else begin : g_trunc
      assign first_bad = !addr_is_canon(first_addr, VA_WIDTH);
      assign last_bad  = !addr_is_canon(last_addr, VA_WIDTH);
    end
  endgenerate
endmodule

// File: rtl/lac_fault_steer.sv
module lac_fault_steer
  import lac_pkg::*;
(
  input  logic [2:0] seg_sel,
  input  logic       stack_base,
  input  logic       noncanon,
  output logic       fault,
  output logic       fault_stack
);
  logic via_stack;

  assign via_stack   = (seg_sel == SEG_SS) || stack_base;
  assign fault       = noncanon;
  assign fault_stack = noncanon && via_stack;
endmodule

// File: rtl/lac_top.sv
module lac_top
  import lac_pkg::*;
#(
  parameter int unsigned VA_WIDTH = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       offset,
  input  logic [2:0]        seg_sel,
  input  logic [63:0]       fs_base,
  input  logic [63:0]       gs_base,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              stack_base,
  output logic              out_valid,
  output logic [63:0]       lin_addr,
  output logic              fault,
  output logic              fault_stack
);
  logic [63:0] lin_c;
  logic [63:0] last_c;
  logic        first_noncanon;
  logic        last_noncanon;
  logic        any_noncanon;
  logic        fault_c;
  logic        stack_c;

  lac_base_sel #(.AW(ADDR_W)) u_base (
    .seg_sel (seg_sel),
    .offset  (offset),
    .fs_base (fs_base),
    .gs_base (gs_base),
    .lin     (lin_c)
  );

  lac_span_check #(.AW(ADDR_W), .VA_WIDTH(VA_WIDTH)) u_span (
    .first_addr (lin_c),
    .acc_size   (acc_size),
    .last_addr  (last_c),
    .first_bad  (first_noncanon),
    .last_bad   (last_noncanon)
  );

  assign any_noncanon = first_noncanon || last_noncanon;

  lac_fault_steer u_steer (
    .seg_sel     (seg_sel),
    .stack_base  (stack_base),
    .noncanon    (any_noncanon),
    .fault       (fault_c),
    .fault_stack (stack_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      lin_addr    <= '0;
      fault       <= 1'b0;
      fault_stack <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      lin_addr    <= lin_c;
      fault       <= in_valid && fault_c;
      fault_stack <= in_valid && stack_c;
    end
  end
endmodule

// File: rtl/lac_checker.sv
module lac_checker #(
  parameter int unsigned VA_WIDTH = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] offset,
  input logic [2:0]  seg_sel,
  input logic        stack_base,
  input logic        first_noncanon,
  input logic        last_noncanon,
  input logic        out_valid,
  input logic [63:0] lin_addr,
  input logic        fault,
  input logic        fault_stack
);
  localparam int unsigned SH = 64 - VA_WIDTH;

  logic off_canon;
  logic plain_seg;
  logic stack_sel;

  assign off_canon = ($signed(offset << SH) >>> SH) == $signed(offset);
  assign plain_seg = (seg_sel != 3'd4) && (seg_sel != 3'd5);
  assign stack_sel = (seg_sel == 3'd2) || stack_base;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_fault_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> out_valid);
  assert_no_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && plain_seg) |=> (lin_addr == $past(offset)));
  assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && plain_seg && !off_canon) |=> fault);
  assert_span_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (first_noncanon || last_noncanon)) |=> fault);
  assert_stack_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stack_sel) |=> (fault_stack == fault));
  assert_gp_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stack_sel) |=> !fault_stack);
endmodule

bind lac_top lac_checker #(.VA_WIDTH(VA_WIDTH)) u_lac_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .offset         (offset),
  .seg_sel        (seg_sel),
  .stack_base     (stack_base),
  .first_noncanon (first_noncanon),
  .last_noncanon  (last_noncanon),
  .out_valid      (out_valid),
  .lin_addr       (lin_addr),
  .fault          (fault),
  .fault_stack    (fault_stack)
);

// File: tb/lac_top_tb.sv
`timescale 1ns/1ps
module lac_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] offset = '0;
  logic [2:0]  seg_sel = '0;
  logic [63:0] fs_base = '0;
  logic [63:0] gs_base = '0;
  logic [4:0]  acc_size = 5'd1;
  logic        stack_base = 1'b0;
  logic        out_valid;
  logic [63:0] lin_addr;
  logic        fault;
  logic        fault_stack;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  lac_top #(.VA_WIDTH(48)) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .offset (offset),
    .seg_sel (seg_sel), .fs_base (fs_base), .gs_base (gs_base),
    .acc_size (acc_size), .stack_base (stack_base), .out_valid (out_valid),
    .lin_addr (lin_addr), .fault (fault), .fault_stack (fault_stack)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  // present one access, sample its result one cycle later
  task automatic run_access(string req, logic [63:0] off, logic [2:0] seg,
                            logic [4:0] sz, logic stk, logic [63:0] exp_lin,
                            logic exp_fault, logic exp_stack);
    @(negedge clk);
    in_valid = 1'b1; offset = off; seg_sel = seg; acc_size = sz; stack_base = stk;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " lin"},   lin_addr, exp_lin);
    check({req, " fault"}, 64'(fault), 64'(exp_fault));
    check({req, " class"}, 64'(fault_stack), 64'(exp_stack));
  endtask

  task automatic t_reset();
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset lin",   lin_addr, 64'd0);
    check("R9 reset fault", 64'(fault), 64'd0);
    check("R9 reset class", 64'(fault_stack), 64'd0);
  endtask

  task automatic t_fs_gs_base();
    fs_base = 64'h0000_1000_0000_0000; gs_base = 64'h0000_0000_0002_0000;
    run_access("R1 fs", 64'h0000_0000_0000_1234, 3'd4, 5'd8, 1'b0, 64'h0000_1000_0000_1234, 1'b0, 1'b0);
    run_access("R1 gs", 64'h0000_0000_0000_0010, 3'd5, 5'd4, 1'b0, 64'h0000_0000_0002_0010, 1'b0, 1'b0);
    fs_base = 64'h0000_7FFF_0000_0000;
    run_access("R1 fs pushes out", 64'h0000_0001_0000_0000, 3'd4, 5'd1, 1'b0, 64'h0000_8000_0000_0000, 1'b1, 1'b0);
    gs_base = 64'hFFFF_FFFF_FFFF_FFF0;
    run_access("R1 gs wrap", 64'h0000_0000_0000_0020, 3'd5, 5'd1, 1'b0, 64'h0000_0000_0000_0010, 1'b0, 1'b0);
  endtask

  task automatic t_bases_ignored();
    fs_base = 64'h1234_5678_9ABC_DEF0; gs_base = 64'h0FED_CBA9_8765_4321;
    for (int s = 0; s < 8; s++) begin
      if (s == 4 || s == 5) continue;
      run_access($sformatf("R2 seg%0d", s), 64'h0000_0000_00AB_C000, 3'(s), 5'd2, 1'b0,
                 64'h0000_0000_00AB_C000, 1'b0, 1'b0);
    end
  endtask

  task automatic t_canonical();
    run_access("R3 low max", 64'h0000_7FFF_FFFF_FFFF, 3'd3, 5'd1, 1'b0, 64'h0000_7FFF_FFFF_FFFF, 1'b0, 1'b0);
    run_access("R3 high min", 64'hFFFF_8000_0000_0000, 3'd3, 5'd1, 1'b0, 64'hFFFF_8000_0000_0000, 1'b0, 1'b0);
    run_access("R3 hole low", 64'h0000_8000_0000_0000, 3'd0, 5'd1, 1'b0, 64'h0000_8000_0000_0000, 1'b1, 1'b0);
    run_access("R3 hole high", 64'hFFFF_7FFF_FFFF_FFFF, 3'd1, 5'd1, 1'b0, 64'hFFFF_7FFF_FFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_span();
    run_access("R4 fits", 64'h0000_7FFF_FFFF_FFF8, 3'd3, 5'd8, 1'b0, 64'h0000_7FFF_FFFF_FFF8, 1'b0, 1'b0);
    run_access("R4 straddle", 64'h0000_7FFF_FFFF_FFF8, 3'd3, 5'd9, 1'b0, 64'h0000_7FFF_FFFF_FFF8, 1'b1, 1'b0);
    run_access("R4 straddle 16", 64'h0000_7FFF_FFFF_FFF1, 3'd0, 5'd16, 1'b0, 64'h0000_7FFF_FFFF_FFF1, 1'b1, 1'b0);
  endtask

  task automatic t_wrap();
    run_access("R5 wrap", 64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 5'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    run_access("R5 wrap 16", 64'hFFFF_FFFF_FFFF_FFF8, 3'd3, 5'd16, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 1'b0);
  endtask

  task automatic t_steering();
    run_access("R6 ss", 64'h8000_0000_0000_0000, 3'd2, 5'd8, 1'b0, 64'h8000_0000_0000_0000, 1'b1, 1'b1);
    run_access("R6 rsp base ds straddle", 64'h0000_7FFF_FFFF_FFFF, 3'd3, 5'd8, 1'b1, 64'h0000_7FFF_FFFF_FFFF, 1'b1, 1'b1);
    run_access("R6 ss no fault", 64'h0000_0000_0000_1000, 3'd2, 5'd8, 1'b1, 64'h0000_0000_0000_1000, 1'b0, 1'b0);
    fs_base = 64'h0;
    run_access("R6 fs gp", 64'h0001_0000_0000_0000, 3'd4, 5'd4, 1'b0, 64'h0001_0000_0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_no_limit();
    run_access("R7 large offset", 64'h0000_7FFF_FFFF_0000, 3'd1, 5'd16, 1'b0, 64'h0000_7FFF_FFFF_0000, 1'b0, 1'b0);
    run_access("R7 high half", 64'hFFFF_FFFF_0000_0000, 3'd2, 5'd16, 1'b0, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_size_clamp();
    run_access("R8 size0", 64'h0000_7FFF_FFFF_FFFF, 3'd3, 5'd0, 1'b0, 64'h0000_7FFF_FFFF_FFFF, 1'b0, 1'b0);
    run_access("R8 size31 fits", 64'h0000_7FFF_FFFF_FFF0, 3'd3, 5'd31, 1'b0, 64'h0000_7FFF_FFFF_FFF0, 1'b0, 1'b0);
    run_access("R8 size17 over", 64'h0000_7FFF_FFFF_FFF1, 3'd3, 5'd17, 1'b0, 64'h0000_7FFF_FFFF_FFF1, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; offset = 64'h0000_8000_0000_0000; seg_sel = 3'd2;
    @(negedge clk);
    check("R9 idle valid", 64'(out_valid), 64'd0);
    check("R9 idle fault", 64'(fault), 64'd0);
    check("R9 idle class", 64'(fault_stack), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fs_gs_base();
    t_bases_ignored();
    t_canonical();
    t_span();
    t_wrap();
    t_steering();
    t_no_limit();
    t_size_clamp();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule